// File: doc/BRIEF.md
# Lane-Coded Protected Command Store

This block holds a small on-board command store in which every stored word is protected against single bit upsets. A 32-bit write word is cut into four 8-bit lanes. Each lane is encoded into a systematic 12-bit codeword, so one address holds 48 physical bits. The array holds 2048 addresses. On a read, each lane is re-checked and any single flipped bit is repaired. The corrected 32-bit word comes back one clock later with a corrected flag and an uncorrectable flag for each lane.

A separate upset port XORs an arbitrary 48-bit mask into one stored word. This lets a test model radiation hits in both data and check positions. Requests arrive on a single valid-qualified port that carries either a read or a write in each cycle. The upset port acts independently of that request port.

Top module: `cmd_edac_store`

## Requirements
- R1: While reset is held and on the first cycle after it, `rsp_valid` is low and both flag vectors are zero.
- R2: A read request (`req_valid`=1, `req_write`=0) raises `rsp_valid` on exactly the next clock. With it comes the word last written at that address, and all flags are clear when no bit has been upset.
- R3: The stored layout places lane i at physical bits 12i..12i+11. Its data bits d0..d7 sit at offsets 0..7, and check bits c0..c3 sit at offsets 8..11. A single flipped data bit in a lane is repaired on read, and only that lane's bit in `rsp_corrected` is set.
- R4: A single flipped check bit in a lane sets that lane's corrected flag and leaves the returned data unchanged.
- R5: Lanes are independent: one upset in each of the four lanes of the same word is repaired in a single read, with all four corrected flags set.
- R6: A lane whose syndrome is nonzero but matches none of its 12 columns raises its `rsp_uncorrectable` bit and leaves `rsp_corrected` clear. That lane's data is returned as stored, without any bit flipped. For example, upsets of d0 and d7 together give syndrome 1111 and fall in this case.
- R7: A write replaces the whole 48-bit stored word, which removes any earlier upset at that address.
- R8: When an upset and a read hit the same address in the same cycle, the read returns the word as it was before the upset. The next read of that address sees the upset.
- R9: When an upset and a write hit the same address in the same cycle, the write wins and the upset mask is discarded.
- R10: The check-bit syndrome columns for d0..d7 are 0011, 0101, 0110, 0111, 1001, 1010, 1011 and 1100, written c3..c0. Each check bit is the XOR of the data bits whose column has a 1 in that position. Upsetting a pair of check bits whose combined column equals a data column therefore inverts that data bit and sets the corrected flag.
- R11: A write request, or a cycle with no read request, leaves `rsp_valid` low on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Word address |
| req_wdata | input | 32 | Write data |
| inj_valid | input | 1 | Apply upset mask this cycle |
| inj_addr | input | 11 | Address to upset |
| inj_mask | input | 48 | Bits to invert in the stored word |
| rsp_valid | output | 1 | Read result valid |
| rsp_rdata | output | 32 | Corrected read data |
| rsp_corrected | output | 4 | Per-lane single-error-repaired flag |
| rsp_uncorrectable | output | 4 | Per-lane unmatched-syndrome flag |

## Verification
The upset port and the request port can act on the same address in the same clock, and the outcome depends on the operation. A read sees the old word. A write overrides the mask. The bench drives both ports in one cycle in each of these combinations, then follows with a plain read of the same address. The delayed result is judged against an expected word and expected flags that the bench derives from the syndrome columns. For a read, the plain read must show the upset repaired. For a write, it must show a clean word.

// File: rtl/edac_pkg.sv
// Package: shared sizes and the (12,8) parity-check column table.
// Assumes one lane = 8 data bits + 4 appended check bits.
package edac_pkg;
    localparam int LANE_D = 8;
    localparam int LANE_C = 4;
    localparam int LANE_W = LANE_D + LANE_C;

    // Syndrome column of data bit i (bit j of the value = check bit cj).
    function automatic logic [LANE_C-1:0] data_col(input int i);
        logic [LANE_C-1:0] col;
        case (i)
            0: col = 4'b0011;
            1: col = 4'b0101;
            2: col = 4'b0110;
            3: col = 4'b0111;
            4: col = 4'b1001;
            5: col = 4'b1010;
            6: col = 4'b1011;
            default: col = 4'b1100;
        endcase
        return col;
    endfunction

    // Data bits that feed check bit j.
    function automatic logic [LANE_D-1:0] chk_taps(input int j);
        logic [LANE_D-1:0] t;
        for (int i = 0; i < LANE_D; i++) begin
            logic [LANE_C-1:0] c;
            c = data_col(i);
            t[i] = c[j];
        end
        return t;
    endfunction
endpackage

// File: rtl/lane_encoder.sv
// Lane encoder: 8 data bits in, systematic 12-bit codeword out
// (data in bits 7:0, check bits in 11:8). Purely combinational.
module lane_encoder
    import edac_pkg::*;
(
    input  logic [LANE_D-1:0] data_i,
    output logic [LANE_W-1:0] code_o
);
    logic [LANE_C-1:0] chk;

    // One XOR tree per check bit over its tap set.
    for (genvar j = 0; j < LANE_C; j++) begin : g_chk
        assign chk[j] = ^(data_i & chk_taps(j));
    end

    assign code_o = {chk, data_i};
endmodule

// File: rtl/lane_decoder.sv
// Lane decoder: recomputes the syndrome of a 12-bit codeword, inverts
// the data bit whose column matches, and flags corrected/unmatched.
// Assumes the layout produced by lane_encoder. Combinational.
module lane_decoder
    import edac_pkg::*;
(
    input  logic [LANE_W-1:0] code_i,
    output logic [LANE_D-1:0] data_o,
    output logic              corrected_o,
    output logic              uncorrectable_o
);
    logic [LANE_D-1:0] rx_data;
    logic [LANE_C-1:0] rx_chk;
    logic [LANE_C-1:0] syndrome;
    logic [LANE_D-1:0] data_hit;
    logic [LANE_C-1:0] chk_hit;

    assign rx_data = code_i[LANE_D-1:0];
    assign rx_chk  = code_i[LANE_W-1:LANE_D];

    // Syndrome: recomputed check bits against received ones.
    for (genvar j = 0; j < LANE_C; j++) begin : g_syn
        assign syndrome[j] = (^(rx_data & chk_taps(j))) ^ rx_chk[j];
    end

    // Compare the syndrome with every data column.
    for (genvar i = 0; i < LANE_D; i++) begin : g_dmatch
        assign data_hit[i] = (syndrome == data_col(i));
    end

    // Compare the syndrome with every identity (check) column.
    for (genvar j = 0; j < LANE_C; j++) begin : g_cmatch
        assign chk_hit[j] = (syndrome == LANE_C'(1 << j));
    end

    assign data_o          = rx_data ^ data_hit;
    assign corrected_o     = (|data_hit) | (|chk_hit);
    assign uncorrectable_o = (syndrome != '0) && !corrected_o;
endmodule

// File: rtl/protected_store.sv
// Protected store array: DEPTH words of WIDTH bits, one write port,
// one registered read port and an XOR upset port. Write to the same
// address as an upset in one cycle overrides the upset; a read in
// the same cycle as an upset returns the pre-upset word.
module protected_store #(
    parameter int DEPTH  = 2048,
    parameter int WIDTH  = 48,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_word,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    input  logic             up_en,
    input  logic [AW-1:0]    up_addr,
    input  logic [WIDTH-1:0] up_mask,
    output logic [WIDTH-1:0] rd_word
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] rd_q;

    // Array update: upset first, then the write so it takes priority.
    always_ff @(posedge clk) begin
        if (up_en) mem[up_addr] <= mem[up_addr] ^ up_mask;
        if (wr_en) mem[wr_addr] <= wr_word;
    end

    // Read register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= mem[rd_addr];
    end

    assign rd_word = rd_q;
endmodule

// File: rtl/cmd_edac_store.sv
// Top: lane-coded protected command store. Encodes each 8-bit lane of
// a write, stores 48 bits per address, and decodes a read one clock
// later with per-lane flags. Assumes at most one request per cycle.
module cmd_edac_store
    import edac_pkg::*;
#(
    parameter int DEPTH  = 2048,
    parameter int LANES  = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = LANES * LANE_D,
    localparam int SW    = LANES * LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          inj_valid,
    input  logic [AW-1:0] inj_addr,
    input  logic [SW-1:0] inj_mask,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [LANES-1:0] rsp_corrected,
    output logic [LANES-1:0] rsp_uncorrectable
);
    logic [SW-1:0] enc_word;
    logic [SW-1:0] raw_word;
    logic          rd_go;
    logic          wr_go;

    assign rd_go = req_valid && !req_write;
    assign wr_go = req_valid &&  req_write;

    // Per-lane encoders and decoders.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lane_encoder u_enc (
            .data_i (req_wdata[l*LANE_D +: LANE_D]),
            .code_o (enc_word[l*LANE_W +: LANE_W])
        );
        lane_decoder u_dec (
            .code_i          (raw_word[l*LANE_W +: LANE_W]),
            .data_o          (rsp_rdata[l*LANE_D +: LANE_D]),
            .corrected_o     (rsp_corrected[l]),
            .uncorrectable_o (rsp_uncorrectable[l])
        );
    end

    protected_store #(.DEPTH(DEPTH), .WIDTH(SW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_go),
        .wr_addr (req_addr),
        .wr_word (enc_word),
        .rd_en   (rd_go),
        .rd_addr (req_addr),
        .up_en   (inj_valid),
        .up_addr (inj_addr),
        .up_mask (inj_mask),
        .rd_word (raw_word)
    );

    // Response strobe: one clock after an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid <= 1'b0;
        else        rsp_valid <= rd_go;
    end
endmodule

// File: rtl/cmd_edac_store_checker.sv
// Checker for cmd_edac_store: response timing and flag consistency.
module cmd_edac_store_checker #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic             rsp_valid,
    input logic [LANES-1:0] rsp_corrected,
    input logic [LANES-1:0] rsp_uncorrectable
);
    // R1: first cycle out of reset has no response.
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> !rsp_valid);

    // R2: a read is answered on the next clock.
    assert_read_answered_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // R11: no response without a read one clock earlier.
    assert_no_spurious_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    // R6: a lane is never both corrected and unmatched.
    assert_flags_disjoint_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_corrected & rsp_uncorrectable) == '0));
endmodule

bind cmd_edac_store cmd_edac_store_checker #(.LANES(LANES)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .req_valid         (req_valid),
    .req_write         (req_write),
    .rsp_valid         (rsp_valid),
    .rsp_corrected     (rsp_corrected),
    .rsp_uncorrectable (rsp_uncorrectable)
);

// File: tb/cmd_edac_store_tb.sv
// Scoreboard bench: driver tasks queue expected read results, a
// monitor pops them when rsp_valid is seen.
module cmd_edac_store_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [10:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        inj_valid = 1'b0;
    logic [10:0] inj_addr = '0;
    logic [47:0] inj_mask = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [3:0]  rsp_corrected;
    logic [3:0]  rsp_uncorrectable;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] data;
        logic [3:0]  corr;
        logic [3:0]  unc;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    cmd_edac_store u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .inj_valid (inj_valid), .inj_addr (inj_addr), .inj_mask (inj_mask),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
        .rsp_corrected (rsp_corrected), .rsp_uncorrectable (rsp_uncorrectable)
    );

    task automatic check(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    // Drive one cycle on both ports; queue expectation for a read.
    task automatic cyc(input bit rv, input bit wr, input logic [10:0] a,
                       input logic [31:0] d, input bit iv,
                       input logic [10:0] ia, input logic [47:0] m,
                       input logic [31:0] ed, input logic [3:0] ec,
                       input logic [3:0] eu, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = rv; req_write = wr; req_addr = a; req_wdata = d;
        inj_valid = iv; inj_addr = ia; inj_mask = m;
        if (rv && !wr) begin
            e.data = ed; e.corr = ec; e.unc = eu; e.tag = tag;
            sb.push_back(e);
        end
        @(negedge clk);
        req_valid = 1'b0; inj_valid = 1'b0;
    endtask

    task automatic wr(input logic [10:0] a, input logic [31:0] d, input string tag);
        cyc(1, 1, a, d, 0, '0, '0, '0, '0, '0, tag);
    endtask

    task automatic rd(input logic [10:0] a, input logic [31:0] ed,
                      input logic [3:0] ec, input logic [3:0] eu, input string tag);
        cyc(1, 0, a, '0, 0, '0, '0, ed, ec, eu, tag);
    endtask

    task automatic up(input logic [10:0] a, input logic [47:0] m);
        cyc(0, 0, '0, '0, 1, a, m, '0, '0, '0, "");
    endtask

    // Monitor: compare every response against the queue head.
    always @(posedge clk) begin
        #1;
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                check(0, "R11", "response with no pending read (act 1, exp 0)");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_rdata == e.data && rsp_corrected == e.corr &&
                      rsp_uncorrectable == e.unc, e.tag,
                      $sformatf("act %h/%b/%b exp %h/%b/%b", rsp_rdata,
                                rsp_corrected, rsp_uncorrectable,
                                e.data, e.corr, e.unc));
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rsp_valid == 0 && rsp_corrected == 0 && rsp_uncorrectable == 0, "R1",
              $sformatf("in reset act %b/%b/%b exp 0/0/0", rsp_valid, rsp_corrected, rsp_uncorrectable));
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(rsp_valid == 0, "R1", $sformatf("after reset act %b exp 0", rsp_valid));

        // R2 / R11: clean write-read, boundary addresses.
        wr(11'd0, 32'hDEADBEEF, "R2");
        check(rsp_valid == 0, "R11", $sformatf("after write act %b exp 0", rsp_valid));
        wr(11'd2047, 32'h12345678, "R2");
        rd(11'd0, 32'hDEADBEEF, 4'b0000, 4'b0000, "R2");
        rd(11'd2047, 32'h12345678, 4'b0000, 4'b0000, "R2");

        // R3: lane2 d3 (bit 27).
        wr(11'd5, 32'hA5C30F96, "R3");
        up(11'd5, 48'd1 << 27);
        rd(11'd5, 32'hA5C30F96, 4'b0100, 4'b0000, "R3");

        // R4: lane1 c2 (bit 12+8+2).
        wr(11'd6, 32'h0BADF00D, "R4");
        up(11'd6, 48'd1 << 22);
        rd(11'd6, 32'h0BADF00D, 4'b0010, 4'b0000, "R4");

        // R5: one upset per lane (bits 7, 12, 35, 41).
        wr(11'd7, 32'hCAFE1234, "R5");
        up(11'd7, (48'd1 << 7) | (48'd1 << 12) | (48'd1 << 35) | (48'd1 << 41));
        rd(11'd7, 32'hCAFE1234, 4'b1111, 4'b0000, "R5");

        // R6: lane0 d0 and d7 -> syndrome 1111, data passes unrepaired.
        wr(11'd8, 32'h11223344, "R6");
        up(11'd8, 48'h81);
        rd(11'd8, 32'h112233C5, 4'b0000, 4'b0001, "R6");

        // R10: check-pair upsets mimic data columns (0011 -> d0, 1001 -> d4).
        wr(11'd9, 32'h00000000, "R10");
        up(11'd9, (48'd3 << 8) | (48'd1 << 44) | (48'd1 << 47));
        rd(11'd9, 32'h10000001, 4'b1001, 4'b0000, "R10");

        // R7: rewrite clears earlier upset.
        wr(11'd5, 32'h55AA55AA, "R7");
        rd(11'd5, 32'h55AA55AA, 4'b0000, 4'b0000, "R7");

        // R8: read and upset of lane0 d1 in one cycle.
        wr(11'd10, 32'h89ABCDEF, "R8");
        cyc(1, 0, 11'd10, '0, 1, 11'd10, 48'd1 << 1, 32'h89ABCDEF, 4'b0000, 4'b0000, "R8");
        rd(11'd10, 32'h89ABCDEF, 4'b0001, 4'b0000, "R8");

        // R9: write and upset of lane3 d2 in one cycle.
        cyc(1, 1, 11'd11, 32'h76543210, 1, 11'd11, 48'd1 << 38, '0, '0, '0, "R9");
        rd(11'd11, 32'h76543210, 4'b0000, 4'b0000, "R9");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R2", $sformatf("pending reads act %0d exp 0", sb.size()));
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            check(0, "R2", "watchdog expired (act hung, exp done)");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule